// File: doc/BRIEF.md
# Sample-Clock Divider with Phase Realignment

This block turns a free-running device clock into a sample-clock enable that fires once every 1, 2 or 4 device-clock cycles. It also produces a registered output clock whose phase is tied to that enable, so downstream capture logic can latch data against it. After power-up the position of the divider inside its period is arbitrary. A seed input sets that position at reset, so a bench can model the arbitrary phase.

A single-cycle divider-realign pulse, sampled on the device clock, puts the counter back at the start of a period. Several instances that share one pulse then produce identical enables and output clocks on the same device-clock edges, whatever their seeds were. A change of the divide select waits for the current period to end. No period is cut short.

Top module: `clkdiv_phase_sync`

## Requirements
- R1: `div_sel` encoding: 0 selects divide-by-1, 1 selects divide-by-2, and 2 or 3 selects divide-by-4. For a divide ratio N, `samp_en` is high for exactly one cycle in every N cycles. It is high during the last cycle of each period, which is counter value N-1.
- R2: For N of 2 or 4, `out_clk` is high while the counter is below N/2 and low for the rest of the period, which gives a 50% duty cycle. For N of 1 it is held high.
- R3: While `rst` is high, each clock edge loads the ratio from `div_sel` and loads the counter with `seed` modulo N.
- R4: When `div_rst` is high at a clock edge, the counter loads zero and the ratio is taken from `div_sel`. `samp_en` is then low for N-1 cycles and goes high in the N-th cycle after that edge.
- R5: In divide-by-1 mode, `samp_en` and `out_clk` are high in every cycle, and `div_rst` has no visible effect on them.
- R6: A change of `div_sel` while `div_rst` is low takes effect only at the edge that ends the current period. That period keeps its full length.
- R7: Two instances with different seeds, the same `div_sel` and a shared `div_rst` pulse give identical `samp_en` and `out_clk` from that pulse onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 2 | Divide-ratio select |
| seed | input | 2 | Counter start value loaded during reset |
| div_rst | input | 1 | Divider phase-realign pulse, sampled on `clk` |
| samp_en | output | 1 | Sample-clock enable, one cycle per period |
| out_clk | output | 1 | Registered output clock at the sample rate |

## Verification
The hardest case to reach from the ports is a select change that arrives while a realigned period is already running. The bench realigns in divide-by-4 and switches to divide-by-2 one cycle later. It then checks that the enable still waits for the full four-cycle period before the shorter period begins. Lockstep behaviour is shown by running two instances that start from different seeds and comparing them edge for edge once the shared pulse has been applied. Divide-by-1 mode is exercised with realign pulses on alternate cycles.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int unsigned DIV_MAX = 4;
    localparam int unsigned CNT_W   = $clog2(DIV_MAX);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        MODE_D1 = 2'd0,
        MODE_D2 = 2'd1,
        MODE_D4 = 2'd2
    } div_mode_e;

    typedef struct packed {
        div_mode_e mode;
        cnt_t      cnt;
    } div_state_t;

    function automatic div_mode_e decode_sel(input logic [1:0] s);
        case (s)
            2'd0:    return MODE_D1;
            2'd1:    return MODE_D2;
            default: return MODE_D4;
        endcase
    endfunction

    function automatic cnt_t last_count(input div_mode_e m);
        case (m)
            MODE_D1: return cnt_t'(0);
            MODE_D2: return cnt_t'(1);
            default: return cnt_t'(DIV_MAX - 1);
        endcase
    endfunction

    function automatic logic high_phase(input div_state_t st);
        case (st.mode)
            MODE_D1: return 1'b1;
            MODE_D2: return (st.cnt == cnt_t'(0));
            default: return (st.cnt < cnt_t'(DIV_MAX / 2));
        endcase
    endfunction

endpackage

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] div_sel,
    input  cnt_t       seed,
    input  logic       div_rst,
    output div_state_t st_q,
    output div_state_t st_d,
    output logic       at_last
);

    div_mode_e sel_mode;

    assign sel_mode = decode_sel(div_sel);
    assign at_last  = (st_q.cnt == last_count(st_q.mode));

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.mode = sel_mode;
            st_d.cnt  = seed & last_count(sel_mode);
        end else if (div_rst) begin
            st_d.mode = sel_mode;
            st_d.cnt  = '0;
        end else if (at_last) begin
            st_d.mode = sel_mode;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt  = cnt_t'(st_q.cnt + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= last_count(st_q.mode)); // R1

    AST_REALIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
        div_rst |=> (st_q.cnt == '0)); // R4

    AST_MODE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (st_q.mode != $past(st_q.mode)))
            |-> $past(at_last || div_rst)); // R6

endmodule

// File: rtl/clkdiv_outgen.sv
module clkdiv_outgen
    import clkdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  div_state_t st_q,
    input  div_state_t st_d,
    input  logic       at_last,
    output logic       samp_en,
    output logic       out_clk
);

    logic oclk_q;

    assign samp_en = at_last;
    assign out_clk = oclk_q;

    always_ff @(posedge clk) begin
        oclk_q <= high_phase(st_d);
    end

    AST_DIV1_ALWAYS_EN: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_D1) |-> (samp_en && out_clk)); // R5

    AST_OCLK_LOW_AT_END: assert property (@(posedge clk) disable iff (rst)
        ((st_q.mode != MODE_D1) && samp_en) |-> !out_clk); // R2

    AST_OCLK_HIGH_AT_START: assert property (@(posedge clk) disable iff (rst)
        ((st_q.mode != MODE_D1) && (st_q.cnt == '0)) |-> out_clk); // R2

endmodule

// File: rtl/clkdiv_phase_sync.sv
module clkdiv_phase_sync
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       div_sel,
    input  logic [CNT_W-1:0] seed,
    input  logic             div_rst,
    output logic             samp_en,
    output logic             out_clk
);

    div_state_t st_q;
    div_state_t st_d;
    logic       at_last;

    clkdiv_counter u_counter (
        .clk     (clk),
        .rst     (rst),
        .div_sel (div_sel),
        .seed    (seed),
        .div_rst (div_rst),
        .st_q    (st_q),
        .st_d    (st_d),
        .at_last (at_last)
    );

    clkdiv_outgen u_outgen (
        .clk     (clk),
        .rst     (rst),
        .st_q    (st_q),
        .st_d    (st_d),
        .at_last (at_last),
        .samp_en (samp_en),
        .out_clk (out_clk)
    );

endmodule

// File: tb/test_clkdiv_phase_sync.sv
module test_clkdiv_phase_sync;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] dsel;
    logic [1:0] seed_a, seed_b;
    logic       drst;
    logic       en_a, oc_a, en_b, oc_b;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    bit aligned = 0;

    int m_div = 1;
    int m_ph  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkdiv_phase_sync i_clkdiv_phase_sync (
        .clk(clk), .rst(rst), .div_sel(dsel), .seed(seed_a),
        .div_rst(drst), .samp_en(en_a), .out_clk(oc_a)
    );

    clkdiv_phase_sync i_clkdiv_phase_sync_peer (
        .clk(clk), .rst(rst), .div_sel(dsel), .seed(seed_b),
        .div_rst(drst), .samp_en(en_b), .out_clk(oc_b)
    );

    function automatic int ratio_of(input logic [1:0] s);
        if (s == 2'd0) return 1;
        if (s == 2'd1) return 2;
        return 4;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference for instance A
    always @(posedge clk) begin
        if (rst) begin
            m_div = ratio_of(dsel);
            m_ph  = int'(seed_a) % m_div;
        end else if (drst || m_ph == m_div - 1) begin
            m_div = ratio_of(dsel);
            m_ph  = 0;
        end else begin
            m_ph  = m_ph + 1;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(en_a === (m_ph == m_div - 1), "R1 samp_en vs model", int'(en_a), int'(m_ph == m_div - 1));
            chk(oc_a === ((m_div == 1) || (m_ph < m_div / 2)), "R2 out_clk vs model",
                int'(oc_a), int'((m_div == 1) || (m_ph < m_div / 2)));
            if (aligned) begin
                chk(en_a === en_b, "R7 samp_en lockstep", int'(en_b), int'(en_a));
                chk(oc_a === oc_b, "R7 out_clk lockstep", int'(oc_b), int'(oc_a));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; dsel = 2'd2; seed_a = 2'd1; seed_b = 2'd3; drst = 1'b0;
        @(negedge clk);
        cmp_on = 1;
        // R3: reset loads seed; A at count 1, B at count 3 in divide-by-4
        chk(en_a === 1'b0 && oc_a === 1'b1, "R3 reset state A", int'({en_a, oc_a}), 1);
        chk(en_b === 1'b1 && oc_b === 1'b0, "R3 reset state B", int'({en_b, oc_b}), 2);
        @(negedge clk);
        rst = 1'b0;
        repeat (7) @(negedge clk);

        // Shared realign pulse brings both instances into lockstep
        drst = 1'b1;
        @(negedge clk);
        drst = 1'b0;
        aligned = 1;
        repeat (12) @(negedge clk);

        // R4 and R6: realign in divide-by-4, then request divide-by-2 mid-period
        drst = 1'b1;
        @(negedge clk);
        drst = 1'b0;
        for (int n = 1; n <= 6; n++) begin
            chk(en_a === ((n == 4) || (n == 6)), (n <= 4) ? "R4 first enable after realign" : "R6 new period length",
                int'(en_a), int'((n == 4) || (n == 6)));
            if (n == 1) dsel = 2'd1;
            if (n < 6) @(negedge clk);
        end
        repeat (6) @(negedge clk);

        // R5: divide-by-1, realign pulses on alternate cycles
        dsel = 2'd0;
        repeat (4) @(negedge clk);
        for (int n = 0; n < 8; n++) begin
            drst = n[0];
            @(negedge clk);
            chk(en_a === 1'b1 && oc_a === 1'b1, "R5 divide-by-1 with realign", int'({en_a, oc_a}), 3);
        end
        drst = 1'b0;

        // R1: select code 3 behaves as divide-by-4
        dsel = 2'd3;
        repeat (16) @(negedge clk);
        dsel = 2'd1;
        repeat (9) @(negedge clk);
        drst = 1'b1;
        @(negedge clk);
        drst = 1'b0;
        repeat (10) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule